// File: doc/BRIEF.md
# Write-Update Snooping Cache Controller

This block is the controller of one private cache in a group of caches that share one atomic bus and keep their copies coherent by broadcasting writes rather than invalidating them. It takes word reads and writes from its processor, looks them up in a small direct-mapped array that holds one word per line, and starts bus reads, update broadcasts and writebacks when the protocol needs them. At the same time it watches the transactions other caches put on the bus. It refreshes its own copy when a peer broadcasts a new word. When a peer reads a line, it reports through a wired-OR shared line that it holds that line, and it supplies the data if it is the owner.

A line that is present is in one of four states: exclusive-clean, shared-clean, shared-owned (shared and dirty, with this cache responsible for memory) and dirty (sole and modified). A line that is not present is simply absent, and there is no separate invalid state. Whether a copy is private is decided by sampling the shared line in the same cycle as this cache's own bus transaction. Memory is written only by a writeback, which happens when an owned or dirty line is evicted.

A bus transaction completes in the single cycle in which `bus_grant` is high. The fill data and the shared line are sampled in that cycle. Snoop requests arrive on the `snp_*` inputs, and the environment never presents a snoop in a cycle in which this cache holds the grant. Bus and snoop commands use the code 1 for read, 2 for update and 3 for writeback.

Top module: `upd_cache_ctrl`

## Requirements
- R1: After reset every line is absent. Snoops of any address report neither shared nor supply. No bus request and no response is pending, and `cpu_req_ready` is high while no snoop is presented.
- R2: A read miss issues exactly one bus read (command 1) for the requested address and fills the line. The line becomes exclusive-clean if `bus_shared_in` is low during the read and shared-clean if it is high. The response returns the fill word.
- R3: A read hit returns the stored word in a one-cycle `cpu_resp_valid` pulse and uses no bus transaction.
- R4: A write to an exclusive-clean or dirty line stores the word, leaves the line dirty, and uses no bus transaction.
- R5: A write to a shared-clean or shared-owned line issues one update (command 2) that carries the address and the new word. The writer becomes shared-owned if `bus_shared_in` is high during the update and dirty if it is low. The request holds its command and data until it is granted.
- R6: A snooped update (command 2) that hits replaces the stored word and leaves the line shared-clean, even if the line was shared-owned or dirty before. It asserts `snp_shared_out` in the same cycle.
- R7: A snooped read (command 1) that hits asserts `snp_shared_out` in the same cycle. A dirty or shared-owned holder also asserts `snp_supply` with the word and becomes shared-owned. An exclusive-clean holder becomes shared-clean.
- R8: A snoop whose address is not present asserts neither output and changes nothing.
- R9: A miss that evicts a dirty or shared-owned line first issues a writeback (command 3) with the victim's address and word, then the read. Evicting a clean line issues no writeback.
- R10: A write miss fills the line as in R2 and then completes the write as in R4 or R5, depending on the fill state.
- R11: `cpu_req_ready` is low while a snoop is presented and while a processor request is in progress.
- R12: A snooped writeback (command 3) asserts no output and leaves the local line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Request accepted on this edge |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Word address |
| cpu_req_wdata | input | DATA_W | Write word |
| cpu_resp_valid | output | 1 | One-cycle completion pulse |
| cpu_resp_rdata | output | DATA_W | Read word (write word for writes) |
| bus_req_valid | output | 1 | Bus transaction requested |
| bus_req_cmd | output | 2 | 1 read, 2 update, 3 writeback |
| bus_req_addr | output | ADDR_W | Transaction address |
| bus_req_data | output | DATA_W | Update or writeback word |
| bus_grant | input | 1 | Transaction completes this cycle |
| bus_shared_in | input | 1 | Wired-OR shared line seen during own transaction |
| bus_rdata | input | DATA_W | Fill word for a read |
| snp_valid | input | 1 | Peer transaction to snoop |
| snp_cmd | input | 2 | Peer command, same codes |
| snp_addr | input | ADDR_W | Peer address |
| snp_data | input | DATA_W | Peer update word |
| snp_shared_out | output | 1 | This cache holds the snooped line |
| snp_supply | output | 1 | This cache supplies the read data |
| snp_supply_data | output | DATA_W | Supplied word |

## Verification
The bench keeps its own model of each line's state and of memory. It mixes processor operations and snoops over three tags that alias onto every index, so evictions of lines in every state come up often. The hidden states are brought out at the ports. A write that stays silent shows dirty or exclusive-clean. A write that issues an update shows a shared state. A snooped read that supplies data shows ownership. A design that kept a shared-owned copy after a peer update would later supply stale data or write back a line it no longer owns. One that skipped the shared sample would later write silently to a line that peers still hold. One that wrote back clean victims, or dropped the writeback of an owned line, shows the wrong transaction sequence before the fill.

// File: rtl/upd_cache_pkg.sv
// Shared types for the write-update cache controller: line states,
// bus command codes and the snoop state transition.
package upd_cache_pkg;

    typedef enum logic [2:0] {
        LN_ABSENT  = 3'd0,
        LN_EXCL    = 3'd1,
        LN_SHCLEAN = 3'd2,
        LN_SHOWN   = 3'd3,
        LN_DIRTY   = 3'd4
    } line_state_t;

    typedef enum logic [1:0] {
        BC_NONE      = 2'd0,
        BC_READ      = 2'd1,
        BC_UPDATE    = 2'd2,
        BC_WRITEBACK = 2'd3
    } bus_cmd_t;

    // True when this cache must eventually write the line to memory.
    function automatic logic is_dirty(line_state_t s);
        return (s == LN_SHOWN) || (s == LN_DIRTY);
    endfunction

    // State of a held line after a peer transaction hits it.
    function automatic line_state_t snoop_next(line_state_t s, bus_cmd_t c);
        line_state_t r;
        r = s;
        case (c)
            BC_READ:   r = is_dirty(s) ? LN_SHOWN : LN_SHCLEAN;
            BC_UPDATE: r = LN_SHCLEAN;
            default:   r = s;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/upd_line_store.sv
// Direct-mapped line store: tag, word and coherence state per line.
// Two combinational read ports (processor, snoop) and two write ports.
// Assumes the two write ports never target a line in the same cycle;
// if they do, the snoop port wins.
module upd_line_store
    import upd_cache_pkg::*;
#(
    parameter int LINES  = 4,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  a_idx,
    output logic [TAG_W-1:0]  a_tag,
    output logic [DATA_W-1:0] a_data,
    output line_state_t       a_state,
    input  logic [IDX_W-1:0]  b_idx,
    output logic [TAG_W-1:0]  b_tag,
    output logic [DATA_W-1:0] b_data,
    output line_state_t       b_state,
    input  logic              p_we,
    input  logic [TAG_W-1:0]  p_tag,
    input  logic [DATA_W-1:0] p_data,
    input  line_state_t       p_state,
    input  logic              s_we,
    input  line_state_t       s_state,
    input  logic              s_data_we,
    input  logic [DATA_W-1:0] s_data
);

    logic [TAG_W-1:0]  line_tag   [LINES];
    logic [DATA_W-1:0] line_data  [LINES];
    line_state_t       line_state [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [TAG_W-1:0]  tag_r;
        logic [DATA_W-1:0] data_r;
        line_state_t       st_r;
        logic              s_hit, p_hit;

        assign s_hit = s_we && (b_idx == IDX_W'(g));
        assign p_hit = p_we && (a_idx == IDX_W'(g));

        // Per-line storage update: snoop port first, then processor port.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_r  <= '0;
                data_r <= '0;
                st_r   <= LN_ABSENT;
            end else if (s_hit) begin
                st_r <= s_state;
                if (s_data_we) data_r <= s_data;
            end else if (p_hit) begin
                tag_r  <= p_tag;
                data_r <= p_data;
                st_r   <= p_state;
            end
        end

        assign line_tag[g]   = tag_r;
        assign line_data[g]  = data_r;
        assign line_state[g] = st_r;
    end

    assign a_tag   = line_tag[a_idx];
    assign a_data  = line_data[a_idx];
    assign a_state = line_state[a_idx];
    assign b_tag   = line_tag[b_idx];
    assign b_data  = line_data[b_idx];
    assign b_state = line_state[b_idx];

    // A new tag may only replace a line that owes memory nothing.
    AST_NO_TAG_OVER_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        !(p_we && !s_we && (p_tag != line_tag[a_idx]) && is_dirty(line_state[a_idx])));  // R9

endmodule

// File: rtl/upd_snoop_unit.sv
// Snoop-side decode: compares a peer transaction with the held line,
// drives the wired-OR shared and supply outputs, and computes the
// state/data update for the line store. Purely combinational.
module upd_snoop_unit
    import upd_cache_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              snp_valid,
    input  bus_cmd_t          snp_cmd,
    input  logic [TAG_W-1:0]  snp_tag,
    input  logic [DATA_W-1:0] snp_data,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic [DATA_W-1:0] line_data,
    input  line_state_t       line_state,
    output logic              shared_out,
    output logic              supply,
    output logic [DATA_W-1:0] supply_data,
    output logic              st_we,
    output line_state_t       st_next,
    output logic              data_we,
    output logic [DATA_W-1:0] data_next
);

    logic hit;

    // Decide whether the peer transaction touches the held copy.
    always_comb begin
        hit         = snp_valid && (line_state != LN_ABSENT) && (line_tag == snp_tag);
        shared_out  = hit && (snp_cmd == BC_READ || snp_cmd == BC_UPDATE);
        supply      = hit && (snp_cmd == BC_READ) && is_dirty(line_state);
        supply_data = supply ? line_data : '0;
        st_we       = shared_out;
        st_next     = snoop_next(line_state, snp_cmd);
        data_we     = hit && (snp_cmd == BC_UPDATE);
        data_next   = snp_data;
    end

endmodule

// File: rtl/upd_proc_ctrl.sv
// Processor-side sequencer. Latches one request, looks it up, and runs
// the writeback / read / update bus transactions the protocol needs.
// Assumes an atomic bus: a granted transaction completes in its grant
// cycle, and no snoop coincides with a grant. Array writes are held
// off in any cycle that carries a snoop.
module upd_proc_ctrl
    import upd_cache_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int LINES  = 4,
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_resp_valid,
    output logic [DATA_W-1:0] cpu_resp_rdata,
    input  logic              snp_valid,
    output logic              bus_req_valid,
    output bus_cmd_t          bus_req_cmd,
    output logic [ADDR_W-1:0] bus_req_addr,
    output logic [DATA_W-1:0] bus_req_data,
    input  logic              bus_grant,
    input  logic              bus_shared_in,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [IDX_W-1:0]  look_idx,
    input  logic [TAG_W-1:0]  a_tag,
    input  logic [DATA_W-1:0] a_data,
    input  line_state_t       a_state,
    output logic              p_we,
    output logic [TAG_W-1:0]  p_tag,
    output logic [DATA_W-1:0] p_data,
    output line_state_t       p_state
);

    typedef enum logic [2:0] {P_IDLE, P_LOOK, P_UPD, P_WB, P_RD} pstate_t;

    pstate_t           pst, nxt;
    logic              req_write;
    logic [ADDR_W-1:0] req_addr;
    logic [DATA_W-1:0] req_wdata;
    logic              resp_set;
    logic [DATA_W-1:0] resp_val;
    logic [TAG_W-1:0]  req_tag;
    logic              hit, take, bus_done;

    assign req_tag       = req_addr[ADDR_W-1:IDX_W];
    assign look_idx      = req_addr[IDX_W-1:0];
    assign hit           = (a_state != LN_ABSENT) && (a_tag == req_tag);
    assign take          = (pst == P_IDLE) && cpu_req_valid && !snp_valid;
    assign cpu_req_ready = (pst == P_IDLE) && !snp_valid;
    assign bus_done      = bus_grant && !snp_valid;

    // Next step, bus request and array write for the current request.
    always_comb begin
        nxt           = pst;
        p_we          = 1'b0;
        p_tag         = a_tag;
        p_data        = a_data;
        p_state       = a_state;
        resp_set      = 1'b0;
        resp_val      = req_wdata;
        bus_req_valid = 1'b0;
        bus_req_cmd   = BC_NONE;
        bus_req_addr  = req_addr;
        bus_req_data  = req_wdata;
        case (pst)
            P_IDLE: if (take) nxt = P_LOOK;
            P_LOOK: if (!snp_valid) begin
                if (hit) begin
                    if (!req_write) begin
                        resp_set = 1'b1;
                        resp_val = a_data;
                        nxt      = P_IDLE;
                    end else if (a_state == LN_EXCL || a_state == LN_DIRTY) begin
                        p_we     = 1'b1;
                        p_data   = req_wdata;
                        p_state  = LN_DIRTY;
                        resp_set = 1'b1;
                        nxt      = P_IDLE;
                    end else begin
                        nxt = P_UPD;
                    end
                end else if (is_dirty(a_state)) begin
                    nxt = P_WB;
                end else begin
                    p_we    = (a_state != LN_ABSENT);
                    p_state = LN_ABSENT;
                    nxt     = P_RD;
                end
            end
            P_UPD: begin
                bus_req_valid = 1'b1;
                bus_req_cmd   = BC_UPDATE;
                if (bus_done) begin
                    p_we     = 1'b1;
                    p_tag    = req_tag;
                    p_data   = req_wdata;
                    p_state  = bus_shared_in ? LN_SHOWN : LN_DIRTY;
                    resp_set = 1'b1;
                    nxt      = P_IDLE;
                end
            end
            P_WB: begin
                if (!is_dirty(a_state)) begin
                    if (!snp_valid) begin
                        p_we    = (a_state != LN_ABSENT);
                        p_state = LN_ABSENT;
                        nxt     = P_RD;
                    end
                end else begin
                    bus_req_valid = 1'b1;
                    bus_req_cmd   = BC_WRITEBACK;
                    bus_req_addr  = {a_tag, look_idx};
                    bus_req_data  = a_data;
                    if (bus_done) begin
                        p_we    = 1'b1;
                        p_state = LN_ABSENT;
                        nxt     = P_RD;
                    end
                end
            end
            P_RD: begin
                bus_req_valid = 1'b1;
                bus_req_cmd   = BC_READ;
                if (bus_done) begin
                    p_we    = 1'b1;
                    p_tag   = req_tag;
                    p_data  = bus_rdata;
                    p_state = bus_shared_in ? LN_SHCLEAN : LN_EXCL;
                    nxt     = P_LOOK;
                end
            end
            default: nxt = P_IDLE;
        endcase
    end

    // Sequencer state, latched request and registered response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pst            <= P_IDLE;
            req_write      <= 1'b0;
            req_addr       <= '0;
            req_wdata      <= '0;
            cpu_resp_valid <= 1'b0;
            cpu_resp_rdata <= '0;
        end else begin
            pst            <= nxt;
            cpu_resp_valid <= resp_set;
            if (resp_set) cpu_resp_rdata <= resp_val;
            if (take) begin
                req_write <= cpu_req_write;
                req_addr  <= cpu_req_addr;
                req_wdata <= cpu_req_wdata;
            end
        end
    end

    AST_UPD_ON_SHARED_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && bus_req_cmd == BC_UPDATE) |-> (a_state == LN_SHCLEAN || a_state == LN_SHOWN));  // R5
    AST_UPD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && bus_req_cmd == BC_UPDATE && !bus_grant) |=>
        (bus_req_valid && bus_req_cmd == BC_UPDATE && $stable(bus_req_data)));  // R5
    AST_READ_NOT_OVER_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && bus_req_cmd == BC_READ) |-> !is_dirty(a_state));  // R9
    AST_SILENT_PRIVATE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (pst == P_LOOK && !snp_valid && hit && req_write && (a_state == LN_EXCL || a_state == LN_DIRTY))
        |=> (!bus_req_valid && cpu_resp_valid));  // R4
    AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_resp_valid |=> !cpu_resp_valid);  // R3

endmodule

// File: rtl/upd_cache_ctrl.sv
// Top of the write-update snooping cache controller: ties the
// processor sequencer and the snoop decoder to the shared line store.
// Assumes an atomic bus where snoops and own grants never coincide.
module upd_cache_ctrl
    import upd_cache_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int LINES  = 4,
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_resp_valid,
    output logic [DATA_W-1:0] cpu_resp_rdata,
    output logic              bus_req_valid,
    output logic [1:0]        bus_req_cmd,
    output logic [ADDR_W-1:0] bus_req_addr,
    output logic [DATA_W-1:0] bus_req_data,
    input  logic              bus_grant,
    input  logic              bus_shared_in,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [DATA_W-1:0] snp_data,
    output logic              snp_shared_out,
    output logic              snp_supply,
    output logic [DATA_W-1:0] snp_supply_data
);

    logic [IDX_W-1:0]  look_idx;
    logic [TAG_W-1:0]  a_tag, b_tag, p_tag;
    logic [DATA_W-1:0] a_data, b_data, p_data, s_data;
    line_state_t       a_state, b_state, p_state, s_state;
    logic              p_we, s_we, s_data_we;
    bus_cmd_t          cmd_out;

    assign bus_req_cmd = cmd_out;

    upd_proc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) u_proc (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
        .cpu_req_wdata(cpu_req_wdata), .cpu_resp_valid(cpu_resp_valid),
        .cpu_resp_rdata(cpu_resp_rdata), .snp_valid(snp_valid),
        .bus_req_valid(bus_req_valid), .bus_req_cmd(cmd_out),
        .bus_req_addr(bus_req_addr), .bus_req_data(bus_req_data),
        .bus_grant(bus_grant), .bus_shared_in(bus_shared_in), .bus_rdata(bus_rdata),
        .look_idx(look_idx), .a_tag(a_tag), .a_data(a_data), .a_state(a_state),
        .p_we(p_we), .p_tag(p_tag), .p_data(p_data), .p_state(p_state)
    );

    upd_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
        .snp_valid(snp_valid), .snp_cmd(bus_cmd_t'(snp_cmd)),
        .snp_tag(snp_addr[ADDR_W-1:IDX_W]), .snp_data(snp_data),
        .line_tag(b_tag), .line_data(b_data), .line_state(b_state),
        .shared_out(snp_shared_out), .supply(snp_supply), .supply_data(snp_supply_data),
        .st_we(s_we), .st_next(s_state), .data_we(s_data_we), .data_next(s_data)
    );

    upd_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .a_idx(look_idx), .a_tag(a_tag), .a_data(a_data), .a_state(a_state),
        .b_idx(snp_addr[IDX_W-1:0]), .b_tag(b_tag), .b_data(b_data), .b_state(b_state),
        .p_we(p_we), .p_tag(p_tag), .p_data(p_data), .p_state(p_state),
        .s_we(s_we), .s_state(s_state), .s_data_we(s_data_we), .s_data(s_data)
    );

    AST_SUPPLY_NEEDS_GRANTLESS: assert property (@(posedge clk) disable iff (!rst_n)
        snp_supply |-> (snp_shared_out && !p_we));  // R7

endmodule

// File: tb/upd_cache_ctrl_tb.sv
// Model-driven bench: directed protocol sequences, then a long mixed
// sweep of processor and snoop operations over aliasing addresses.
module upd_cache_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
    logic [7:0]  cpu_req_addr = '0;
    logic [15:0] cpu_req_wdata = '0;
    logic        cpu_req_ready, cpu_resp_valid;
    logic [15:0] cpu_resp_rdata;
    logic        bus_req_valid;
    logic [1:0]  bus_req_cmd;
    logic [7:0]  bus_req_addr;
    logic [15:0] bus_req_data;
    logic        bus_grant = 1'b0, bus_shared_in = 1'b0;
    logic [15:0] bus_rdata = '0;
    logic        snp_valid = 1'b0;
    logic [1:0]  snp_cmd = '0;
    logic [7:0]  snp_addr = '0;
    logic [15:0] snp_data = '0;
    logic        snp_shared_out, snp_supply;
    logic [15:0] snp_supply_data;

    int n_cmp = 0, n_bad = 0, cycles = 0;
    int          m_st  [4];
    int          m_tag [4];
    logic [15:0] m_dat [4];
    logic [15:0] mem   [16];
    logic [31:0] seed = 32'h1234_5678;

    always #2 clk = ~clk;

    upd_cache_ctrl u_dut (.*);

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed >> 8;
    endfunction

    // States in the model: 0 absent, 1 excl-clean, 2 shared-clean, 3 shared-owned, 4 dirty.
    task automatic cpu_op(input bit wr, input int addr, input logic [15:0] wd, input bit sh);
        int idx = addr % 4;
        int tg = addr / 4;
        int ecmd [3];
        int eaddr [3];
        logic [15:0] edat [3];
        int ne = 0, seen = 0;
        bit hit, done;
        logic [15:0] eresp;
        string ctag;
        hit = (m_st[idx] != 0) && (m_tag[idx] == tg);
        if (!hit) begin
            ctag = wr ? "R10 write miss" : "R2 read miss";
            if (m_st[idx] >= 3) begin
                ecmd[ne] = 3; eaddr[ne] = m_tag[idx] * 4 + idx; edat[ne] = m_dat[idx]; ne++;
                mem[m_tag[idx] * 4 + idx] = m_dat[idx];
            end
            ecmd[ne] = 1; eaddr[ne] = addr; edat[ne] = '0; ne++;
            m_st[idx] = sh ? 2 : 1; m_tag[idx] = tg; m_dat[idx] = mem[addr];
        end else begin
            ctag = !wr ? "R3 read hit" : ((m_st[idx] == 1 || m_st[idx] == 4) ? "R4 private write" : "R5 shared write");
        end
        eresp = m_dat[idx];
        if (wr) begin
            if (m_st[idx] == 2 || m_st[idx] == 3) begin
                ecmd[ne] = 2; eaddr[ne] = addr; edat[ne] = wd; ne++;
                m_st[idx] = sh ? 3 : 4;
            end else begin
                m_st[idx] = 4;
            end
            m_dat[idx] = wd;
        end
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = 8'(addr); cpu_req_wdata = wd;
        chk(cpu_req_ready == 1'b1, "R11 ready when idle", 32'(cpu_req_ready), 1);
        @(negedge clk);
        cpu_req_valid = 1'b0;
        chk(cpu_req_ready == 1'b0, "R11 ready low while busy", 32'(cpu_req_ready), 0);
        done = 1'b0;
        for (int c = 0; c < 40 && !done; c++) begin
            if (cpu_resp_valid) begin
                done = 1'b1;
            end else begin
                if (bus_req_valid) begin
                    if (seen >= ne) begin
                        chk(1'b0, {ctag, " extra bus transaction"}, 32'(bus_req_cmd), 0);
                    end else begin
                        string tt;
                        tt = (ecmd[seen] == 1) ? "R2 bus read" : (ecmd[seen] == 2) ? "R5 update" : "R9 writeback";
                        chk(bus_req_cmd == 2'(ecmd[seen]), {tt, " cmd"}, 32'(bus_req_cmd), 32'(ecmd[seen]));
                        chk(bus_req_addr == 8'(eaddr[seen]), {tt, " addr"}, 32'(bus_req_addr), 32'(eaddr[seen]));
                        if (ecmd[seen] != 1)
                            chk(bus_req_data == edat[seen], {tt, " data"}, 32'(bus_req_data), 32'(edat[seen]));
                    end
                    seen++;
                    bus_grant = 1'b1; bus_shared_in = sh; bus_rdata = mem[bus_req_addr[3:0]];
                end else begin
                    bus_grant = 1'b0; bus_shared_in = 1'b0;
                end
                @(negedge clk);
            end
        end
        bus_grant = 1'b0; bus_shared_in = 1'b0;
        chk(done, {ctag, " response arrives"}, 32'(done), 1);
        chk(seen == ne, {ctag, " transaction count"}, 32'(seen), 32'(ne));
        if (!wr) chk(cpu_resp_rdata == eresp, {ctag, " read data"}, 32'(cpu_resp_rdata), 32'(eresp));
        @(negedge clk);
        chk(cpu_resp_valid == 1'b0, "R3 response is one cycle", 32'(cpu_resp_valid), 0);
    endtask

    task automatic snoop(input int cmd, input int addr, input logic [15:0] d);
        int idx = addr % 4;
        bit hit;
        string t;
        hit = (m_st[idx] != 0) && (m_tag[idx] == addr / 4);
        t = (cmd == 3) ? "R12 snooped writeback" : !hit ? "R8 snoop miss" :
            (cmd == 2) ? "R6 snooped update" : "R7 snooped read";
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = 2'(cmd); snp_addr = 8'(addr); snp_data = d;
        #1;
        chk(snp_shared_out == (hit && cmd != 3), {t, " shared"}, 32'(snp_shared_out), 32'(hit && cmd != 3));
        chk(snp_supply == (hit && cmd == 1 && m_st[idx] >= 3), {t, " supply"}, 32'(snp_supply),
            32'(hit && cmd == 1 && m_st[idx] >= 3));
        if (hit && cmd == 1 && m_st[idx] >= 3)
            chk(snp_supply_data == m_dat[idx], {t, " supply data"}, 32'(snp_supply_data), 32'(m_dat[idx]));
        chk(cpu_req_ready == 1'b0, "R11 ready low during snoop", 32'(cpu_req_ready), 0);
        if (hit && cmd == 1) m_st[idx] = (m_st[idx] >= 3) ? 3 : 2;
        if (hit && cmd == 2) begin m_st[idx] = 2; m_dat[idx] = d; end
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin m_st[i] = 0; m_tag[i] = 0; m_dat[i] = '0; end
        for (int i = 0; i < 16; i++) mem[i] = 16'h1000 + 16'(i * 7);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus_req_valid == 1'b0, "R1 no bus request after reset", 32'(bus_req_valid), 0);
        chk(cpu_resp_valid == 1'b0, "R1 no response after reset", 32'(cpu_resp_valid), 0);
        chk(cpu_req_ready == 1'b1, "R1 ready after reset", 32'(cpu_req_ready), 1);
        for (int a = 0; a < 12; a++) begin
            @(negedge clk);
            snp_valid = 1'b1; snp_cmd = 2'd1; snp_addr = 8'(a);
            #1;
            chk(!snp_shared_out && !snp_supply, "R1 all lines absent", {snp_shared_out, snp_supply}, 0);
        end
        @(negedge clk) snp_valid = 1'b0;

        cpu_op(0, 1, 0, 0);            // R2 fill exclusive-clean
        cpu_op(1, 1, 16'hA001, 1);     // R4 silent write to exclusive-clean
        snoop(1, 1, 0);                // R7 dirty holder supplies, becomes owner
        cpu_op(1, 1, 16'hA002, 1);     // R5 owner write, shared stays high
        snoop(2, 1, 16'hB003);         // R6 peer update demotes owner
        snoop(1, 1, 0);                // R7 shared-clean: no supply
        cpu_op(0, 1, 0, 0);            // R3 hit returns updated word
        cpu_op(1, 1, 16'hA004, 0);     // R5 update with shared low -> dirty
        cpu_op(1, 1, 16'hA005, 0);     // R4 now silent
        snoop(3, 1, 16'hFFFF);         // R12 writeback ignored
        snoop(1, 5, 0);                // R8 other tag misses
        cpu_op(0, 5, 0, 1);            // R9 dirty eviction then shared fill
        cpu_op(1, 5, 16'hA006, 1);     // R5 update from shared-clean
        cpu_op(0, 9, 0, 0);            // R9 owner eviction
        cpu_op(1, 2, 16'hA007, 1);     // R10 write miss fills shared then updates
        cpu_op(1, 6, 16'hA008, 0);     // R10 write miss, owner evicted first
        cpu_op(0, 1, 0, 0);            // R9 clean eviction is silent

        for (int k = 0; k < 2500; k++) begin
            logic [31:0] r;
            int addr;
            r = rnd();
            addr = int'(r[3:0] % 12);
            if (r[6:4] < 3'd5) cpu_op(r[7], addr, 16'(rnd()), r[8]);
            else snoop(int'(r[10:9] % 3) + 1, addr, 16'(rnd()));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule